// File: doc/BRIEF.md
# Prioritized interrupt pending controller

This block collects 32 level-sensitive interrupt lines and keeps one pending flag per line. A rising level sets that flag, and so does a software write. The flag is set whether or not the line is enabled. Software reaches the block through a plain 32-bit word register port. Through it, software sets and clears enables, sets and clears pending flags, programs a 2-bit priority for each line, and retires the interrupt in service.

An arbiter looks at every line that is both enabled and pending. It offers the most urgent one to the processor core as a request flag, an interrupt number and a priority. When the core acknowledges, the winner leaves the pending set and becomes active. No further request is offered until software retires the active interrupt.

A small service state machine sequences the handshake. Its states are `S_IDLE`, `S_REQ` and `S_SERV`, and its transitions are:
- `S_IDLE` goes to `S_REQ` when a candidate appears.
- `S_REQ` goes to `S_IDLE` when the candidates vanish.
- `S_REQ` goes to `S_SERV` on acknowledge.
- `S_SERV` goes to `S_REQ` when the active set empties and candidates remain.
- `S_SERV` goes to `S_IDLE` when the active set empties and no candidate remains.

Top module: `irq_prio_ctrl`

Word addresses (`bus_addr`):

| Word | Write (1 bits) | Read |
|------|----------------|------|
| 0 | enable | enables |
| 1 | disable | enables |
| 2 | set pending | pending |
| 3 | clear pending | pending |
| 4 | clear active (end of interrupt) | active |
| 8..15 | priorities | priorities |

Access size codes on `bus_size`: 0 is byte, 1 is halfword, 2 is word.

## Requirements
- R1: Writing word 3 clears the pending flag of each line whose data bit is 1. Data bits of 0 leave the flag untouched.
- R2: Reading word 2 or word 3 returns the pending flags, bit i for line i, with 1 meaning pending.
- R3: Clearing a pending flag never changes the active flags.
- R4: Line 4n+k has its priority in byte k of word 8+n, with byte 0 in bits [7:0]. Only bits [7:6] of each byte are stored, and bits [5:0] read as zero.
- R5: On words 8..15, a byte or halfword access is ignored. Such an access returns zero read data and raises `bus_err` in the same cycle.
- R6: A rising edge on a line sets its pending flag even while the line is disabled. `irq_req` is only raised for a line that is both enabled and pending.
- R7: The offered interrupt has the lowest priority value among the eligible lines. On a tie, the lowest line number is offered.
- R8: Writing word 0 enables, and writing word 1 disables, each line whose data bit is 1. Either word reads back the enables.
- R9: `irq_ack` during `irq_req` clears the winner's pending flag and sets its active flag. While any line is active, `irq_req` stays low.
- R10: A rising edge on a line that is active sets its pending flag again.
- R11: Writing word 4 clears the active flags at the 1 bits. Once no line is active, the next eligible line is offered.
- R12: After reset, all enables, pending flags, active flags and priorities are zero, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Narrow access to priority words |
| irq_lvl | input | 32 | Interrupt request levels |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_req | output | 1 | Interrupt offered to core |
| irq_id | output | 5 | Offered line number |
| irq_prio | output | 2 | Offered priority |

## Verification
- Read data and `bus_err` are combinational, so the bench samples them one time step after driving a read.
- A write or a line edge lands at the next clock edge. A new request then needs one more edge for the state machine to enter `S_REQ`, so the bench waits two falling edges after a line rises before it checks `irq_req`.
- Once in `S_REQ`, changes to enables or pending flags move `irq_id` in the cycle right after the write edge.
- An end-of-interrupt write shows as a request one edge after the write edge. The bench drives on falling edges and checks at exactly those points.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_SERV = 2'd2
    } arb_state_t;

    localparam int unsigned W_EN_SET    = 0;
    localparam int unsigned W_EN_CLR    = 1;
    localparam int unsigned W_PEND_SET  = 2;
    localparam int unsigned W_PEND_CLR  = 3;
    localparam int unsigned W_ACT       = 4;
    localparam int unsigned W_PRIO_BASE = 8;

    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam int unsigned BUS_W  = 32;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned PRIO_W = 2,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [1:0]                    bus_size,
    input  logic [BUS_W-1:0]              bus_wdata,
    input  logic [N_IRQ-1:0]              pend_q,
    input  logic [N_IRQ-1:0]              active_q,
    output logic [N_IRQ-1:0]              en_q,
    output logic [N_IRQ-1:0][PRIO_W-1:0]  prio_q,
    output logic [N_IRQ-1:0]              set_pend_mask,
    output logic [N_IRQ-1:0]              clr_pend_mask,
    output logic [N_IRQ-1:0]              eoi_mask,
    output logic [BUS_W-1:0]              bus_rdata,
    output logic                          bus_err
);
    localparam int unsigned N_PREG = N_IRQ / 4;
    localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(W_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(W_EN_CLR);
    localparam logic [ADDR_W-1:0] A_PEND_SET = ADDR_W'(W_PEND_SET);
    localparam logic [ADDR_W-1:0] A_PEND_CLR = ADDR_W'(W_PEND_CLR);
    localparam logic [ADDR_W-1:0] A_ACT      = ADDR_W'(W_ACT);
    localparam logic [ADDR_W-1:0] A_PRIO_LO  = ADDR_W'(W_PRIO_BASE);
    localparam logic [ADDR_W-1:0] A_PRIO_HI  = ADDR_W'(W_PRIO_BASE + N_PREG);

    logic                wr;
    logic                prio_hit;
    logic                prio_wr;
    logic [ADDR_W-1:0]   prio_idx;
    logic [BUS_W-1:0]    prio_rd;

    assign wr       = bus_sel && bus_we;
    assign prio_hit = (bus_addr >= A_PRIO_LO) && (bus_addr < A_PRIO_HI);
    assign prio_idx = bus_addr - A_PRIO_LO;
    assign prio_wr  = wr && prio_hit && (bus_size == SZ_WORD);

    // write-1 masks toward the pending/active tracker
    assign set_pend_mask = (wr && bus_addr == A_PEND_SET) ? bus_wdata[N_IRQ-1:0] : '0;
    assign clr_pend_mask = (wr && bus_addr == A_PEND_CLR) ? bus_wdata[N_IRQ-1:0] : '0;
    assign eoi_mask      = (wr && bus_addr == A_ACT)      ? bus_wdata[N_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr && bus_addr == A_EN_SET) begin
            en_q <= en_q | bus_wdata[N_IRQ-1:0];
        end else if (wr && bus_addr == A_EN_CLR) begin
            en_q <= en_q & ~bus_wdata[N_IRQ-1:0];
        end
    end

    // one priority field per line, taken from the top bits of its byte lane
    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[gi] <= '0;
            end else if (prio_wr && prio_idx == ADDR_W'(gi / 4)) begin
                prio_q[gi] <= bus_wdata[(gi % 4) * 8 + 7 -: PRIO_W];
            end
        end
    end

    always_comb begin
        prio_rd = '0;
        for (int j = 0; j < 4; j++) begin
            if (int'(prio_idx) * 4 + j < N_IRQ) begin
                prio_rd[j * 8 + 7 -: PRIO_W] = prio_q[int'(prio_idx) * 4 + j];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        if (bus_sel) begin
            if (prio_hit) begin
                if (bus_size == SZ_WORD) begin
                    bus_rdata = bus_we ? '0 : prio_rd;
                end else begin
                    bus_err = 1'b1;
                end
            end else if (!bus_we) begin
                if (bus_addr == A_EN_SET || bus_addr == A_EN_CLR) begin
                    bus_rdata[N_IRQ-1:0] = en_q;
                end else if (bus_addr == A_PEND_SET || bus_addr == A_PEND_CLR) begin
                    bus_rdata[N_IRQ-1:0] = pend_q;
                end else if (bus_addr == A_ACT) begin
                    bus_rdata[N_IRQ-1:0] = active_q;
                end
            end
        end
    end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int unsigned N_IRQ = 32,
    parameter int unsigned ID_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_lvl,
    input  logic [N_IRQ-1:0] set_mask,
    input  logic [N_IRQ-1:0] clr_mask,
    input  logic [N_IRQ-1:0] eoi_mask,
    input  logic             ack_fire,
    input  logic [ID_W-1:0]  ack_id,
    output logic [N_IRQ-1:0] pend_q,
    output logic [N_IRQ-1:0] active_q
);
    logic [N_IRQ-1:0] lvl_q;
    logic [N_IRQ-1:0] rise;
    logic [N_IRQ-1:0] ack_vec;

    assign rise = irq_lvl & ~lvl_q;

    always_comb begin
        ack_vec = '0;
        if (ack_fire) begin
            ack_vec[ack_id] = 1'b1;
        end
    end

    // a new edge or a software set beats a clear landing in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            pend_q   <= '0;
            active_q <= '0;
        end else begin
            lvl_q    <= irq_lvl;
            pend_q   <= (pend_q & ~clr_mask & ~ack_vec) | rise | set_mask;
            active_q <= (active_q & ~eoi_mask) | ack_vec;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned PRIO_W = 2,
    parameter int unsigned ID_W   = 5
) (
    input  logic [N_IRQ-1:0]              elig,
    input  logic [N_IRQ-1:0][PRIO_W-1:0]  prio,
    output logic                          any,
    output logic [ID_W-1:0]               win_id,
    output logic [PRIO_W-1:0]             win_prio
);
    // scan downward with <= so the lowest number survives a tie
    always_comb begin
        any      = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i] && (!any || prio[i] <= win_prio)) begin
                any      = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned PRIO_W = 2,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned ID_W  = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [N_IRQ-1:0]  irq_lvl,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic [PRIO_W-1:0] irq_prio
);
    logic [N_IRQ-1:0]             en_q;
    logic [N_IRQ-1:0]             pend_q;
    logic [N_IRQ-1:0]             active_q;
    logic [N_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic [N_IRQ-1:0]             set_pend_mask;
    logic [N_IRQ-1:0]             clr_pend_mask;
    logic [N_IRQ-1:0]             eoi_mask;
    logic                         any;
    logic [ID_W-1:0]              win_id;
    logic [PRIO_W-1:0]            win_prio;
    logic                         ack_fire;
    arb_state_t                   state_q;
    arb_state_t                   state_d;

    irq_regfile #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .pend_q(pend_q), .active_q(active_q),
        .en_q(en_q), .prio_q(prio_q),
        .set_pend_mask(set_pend_mask), .clr_pend_mask(clr_pend_mask),
        .eoi_mask(eoi_mask),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    irq_pend_track #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_track (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl),
        .set_mask(set_pend_mask), .clr_mask(clr_pend_mask),
        .eoi_mask(eoi_mask), .ack_fire(ack_fire), .ack_id(win_id),
        .pend_q(pend_q), .active_q(active_q)
    );

    irq_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .elig(en_q & pend_q), .prio(prio_q),
        .any(any), .win_id(win_id), .win_prio(win_prio)
    );

    assign ack_fire = irq_ack && irq_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any) state_d = S_REQ;
            S_REQ: begin
                if (!any)          state_d = S_IDLE;
                else if (irq_ack)  state_d = S_SERV;
            end
            S_SERV: if (active_q == '0) state_d = any ? S_REQ : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        irq_req  = 1'b0;
        irq_id   = '0;
        irq_prio = '0;
        unique case (state_q)
            S_REQ: begin
                irq_req  = any;
                irq_id   = any ? win_id : '0;
                irq_prio = any ? win_prio : '0;
            end
            S_IDLE, S_SERV: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int unsigned N_IRQ  = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned ID_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [ID_W-1:0]   irq_id,
    input logic [N_IRQ-1:0]  en_q,
    input logic [N_IRQ-1:0]  pend_q,
    input logic [N_IRQ-1:0]  active_q,
    input logic [N_IRQ-1:0]  clr_pend_mask
);
    a_r6_req_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_q[irq_id] && pend_q[irq_id]));

    a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> active_q[$past(irq_id)]);

    a_r9_quiet_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != '0) |-> !irq_req);

    a_r3_clear_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_pend_mask != '0) && !(irq_req && irq_ack)) |=> active_q == $past(active_q));

    a_r9_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_q));

    a_r5_narrow_error: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr >= 6'd8 && bus_addr < 6'd16 && bus_size != 2'd2)
            |-> (bus_err && bus_rdata == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_id(irq_id),
    .en_q(en_q), .pend_q(pend_q), .active_q(active_q),
    .clr_pend_mask(clr_pend_mask)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] irq_lvl = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [4:0]  irq_id;
    logic [1:0]  irq_prio;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_lvl(irq_lvl),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    // {word address, write data, expected read-back}
    localparam logic [69:0] VEC [6] = '{
        {6'd8,  32'hFFFF_FFFF, 32'hC0C0_C0C0},
        {6'd9,  32'h3F3F_3F3F, 32'h0000_0000},
        {6'd15, 32'h1234_5678, 32'h0000_4040},
        {6'd12, 32'h80C0_4000, 32'h80C0_4000},
        {6'd10, 32'hA5A5_A5A5, 32'h8080_8080},
        {6'd8,  32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [1:0] sz);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] sz,
                      output logic [31:0] d, output logic e);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
        e = bus_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_size = 2'd2;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R12 reset state
        check("R12 req", {31'd0, irq_req}, 32'd0);
        rd(6'd0, 2'd2, d, e); check("R12 enables", d, 32'd0);
        rd(6'd3, 2'd2, d, e); check("R12 pending", d, 32'd0);
        rd(6'd4, 2'd2, d, e); check("R12 active", d, 32'd0);
        rd(6'd11, 2'd2, d, e); check("R12 prio", d, 32'd0);

        // R4 priority byte layout table
        for (int v = 0; v < 6; v++) begin
            wr(VEC[v][69:64], VEC[v][63:32], 2'd2);
            rd(VEC[v][69:64], 2'd2, d, e);
            check("R4 prio readback", d, VEC[v][31:0]);
        end

        // lines 0..3: prio 3,1,1,2 ; enable 0..3 (R8)
        wr(6'd8, 32'h8040_40C0, 2'd2);
        wr(6'd0, 32'h0000_000F, 2'd2);
        rd(6'd1, 2'd2, d, e); check("R8 enable read", d, 32'h0000_000F);

        // R6 line 5 disabled still pends, R7 tie lowest number at prio 1
        irq_lvl = 32'h0000_002F;
        step(2);
        check("R6 req raised", {31'd0, irq_req}, 32'd1);
        check("R7 winner id", {27'd0, irq_id}, 32'd1);
        check("R7 winner prio", {30'd0, irq_prio}, 32'd1);
        rd(6'd2, 2'd2, d, e); check("R6 R2 pending incl disabled", d, 32'h0000_002F);

        // R9 acknowledge
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        check("R9 req drops", {31'd0, irq_req}, 32'd0);
        rd(6'd4, 2'd2, d, e); check("R9 active set", d, 32'h0000_0002);
        rd(6'd3, 2'd2, d, e); check("R9 pending cleared", d, 32'h0000_002D);

        // R10 re-pend while active
        irq_lvl[1] = 1'b0;
        step(1);
        irq_lvl[1] = 1'b1;
        step(2);
        rd(6'd3, 2'd2, d, e); check("R10 pend again", d, 32'h0000_002F);
        check("R9 quiet while active", {31'd0, irq_req}, 32'd0);

        // R3 clear pending keeps active ; R1 zero write no effect
        wr(6'd3, 32'h0000_0002, 2'd2);
        rd(6'd4, 2'd2, d, e); check("R3 active kept", d, 32'h0000_0002);
        rd(6'd3, 2'd2, d, e); check("R1 pend cleared", d, 32'h0000_002D);
        wr(6'd3, 32'h0000_0000, 2'd2);
        rd(6'd3, 2'd2, d, e); check("R1 zero write", d, 32'h0000_002D);

        // R11 end of interrupt
        wr(6'd4, 32'h0000_0002, 2'd2);
        step(1);
        check("R11 next req", {31'd0, irq_req}, 32'd1);
        check("R11 next id", {27'd0, irq_id}, 32'd2);
        rd(6'd4, 2'd2, d, e); check("R11 active cleared", d, 32'd0);

        // R8 disable line 2 -> line 3 (prio 2) beats line 0 (prio 3)
        wr(6'd1, 32'h0000_0004, 2'd2);
        check("R8 R7 id after disable", {27'd0, irq_id}, 32'd3);
        check("R7 prio after disable", {30'd0, irq_prio}, 32'd2);
        rd(6'd0, 2'd2, d, e); check("R8 enables", d, 32'h0000_000B);

        // R5 narrow accesses on priority words
        wr(6'd8, 32'h0000_0000, 2'd0);
        rd(6'd8, 2'd2, d, e); check("R5 byte write ignored", d, 32'h8040_40C0);
        rd(6'd8, 2'd1, d, e);
        check("R5 half read zero", d, 32'd0);
        check("R5 half read err", {31'd0, e}, 32'd1);
        rd(6'd8, 2'd2, d, e); check("R5 word no err", {31'd0, e}, 32'd0);

        // R1 mass clear, R11 retire all -> idle
        wr(6'd3, 32'hFFFF_FFFF, 2'd2);
        step(1);
        check("R1 all cleared no req", {31'd0, irq_req}, 32'd0);
        rd(6'd2, 2'd2, d, e); check("R2 pending empty", d, 32'd0);

        // R6 software pend of disabled line gives no request
        wr(6'd2, 32'h0000_0100, 2'd2);
        step(1);
        check("R6 disabled no req", {31'd0, irq_req}, 32'd0);
        rd(6'd3, 2'd2, d, e); check("R6 soft pend", d, 32'h0000_0100);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule